// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Bounded Access Arbitration

This block keeps an asynchronous DRAM refreshed by issuing CAS-before-RAS refresh cycles on a fixed schedule. It shares the command pins with a simple access path. A free-running interval counter raises a one-cycle refresh strobe at a fixed period. The strobe arms a pending flag. That flag blocks new accesses until the controller is back in its idle state, and then a fixed pin pattern follows.

An access runs for as long as the requester keeps it open, up to a hard cap. Because of the cap, a refresh never waits more than a bounded number of cycles. The controller state is brought out as a 3-bit code so that neighbouring logic, and the checker, can follow the sequence. Address multiplexing, data paths and power-up initialisation live elsewhere.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset_n is low, rasN, casN and weN are high, refreshStb is low and memState is 0 (idle). The reset acts asynchronously.
- R2: The first refreshStb pulse is seen at the 25th rising clock edge after the edge at which reset_n is first sampled high. With the default interval of 24, this leaves 24 strobe-free edges in between.
- R3: refreshStb is a single-cycle pulse. Each later pulse follows the previous one by exactly 25 clock cycles.
- R4: memState encodes the states as follows: idle=0, access=1, refresh-CAS=2, refresh-gap=3, refresh-both-A=4, refresh-both-B=5, refresh-close=6. In idle, all three command pins are high.
- R5: In idle with no refresh pending, a sampled accReq moves the controller to access on the next cycle. During access, rasN is low while casN and weN are high. A sampled accDone returns the controller to idle on the next cycle.
- R6: An access never lasts more than 14 consecutive cycles. After the 14th cycle, the controller returns to idle even if accDone stays low.
- R7: From the cycle in which refreshStb is high until the refresh sequence starts, accReq is ignored, so no access begins.
- R8: After refreshStb rises, the controller spends at most 14 cycles outside idle. It then spends exactly one cycle in idle and moves to refresh-CAS on the next cycle.
- R9: The refresh pin sequence runs over five cycles:
  - first, casN is low with rasN and weN high;
  - second, one gap cycle, driven like the first;
  - third and fourth, rasN and casN are both low with weN high;
  - fifth, a close cycle with all pins high.
  The controller then returns to idle.
- R10: A fall of reset_n in the middle of a refresh sequence abandons it at once, restoring the pins and state of R1. The next strobe is then timed again from reset release, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all behaviour is sampled on its rising edge |
| reset_n | input | 1 | Asynchronous active-low reset |
| accReq | input | 1 | Request to open an access |
| accDone | input | 1 | Requester closes the open access |
| rasN | output | 1 | Active-low row strobe |
| casN | output | 1 | Active-low column strobe |
| weN | output | 1 | Active-low write enable |
| refreshStb | output | 1 | One-cycle refresh interval strobe |
| memState | output | 3 | Controller state code (see R4) |

## Verification
The hardest case to reach is the longest refresh wait. It needs an access that opens at the very edge where the strobe fires, and is then held until the 14-cycle cap closes it. The bench holds accReq high with accDone low for long stretches. Back-to-back capped accesses then sweep across every phase of the 25-cycle interval, so some strobe lands at the start of an access. A long randomised phase and a reset dropped in the middle of the double-low part of a refresh cover the remaining orderings.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  // Encoding is visible on memState; neighbours decode it.
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ACCESS     = 3'd1,
    ST_CBR_CAS    = 3'd2,
    ST_CBR_GAP    = 3'd3,
    ST_CBR_BOTH_A = 3'd4,
    ST_CBR_BOTH_B = 3'd5,
    ST_CBR_CLOSE  = 3'd6
  } memState_e;

  // Control -> datapath strobes.
  typedef struct packed {
    logic accStart;
    logic accStep;
    logic pendClear;
  } ctlStrobe_t;

  // Datapath -> control status.
  typedef struct packed {
    logic pending;
    logic accExpired;
  } dpStatus_t;

  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
  } pinSet_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL     = 24,
  parameter int ACCESS_LIMIT = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output dpStatus_t  status,
  output logic       refreshStb
);

  localparam int PERIOD = INTERVAL + 1;
  localparam int GW     = $clog2(PERIOD + 1);
  localparam int AW     = $clog2(ACCESS_LIMIT + 1);

  logic [GW-1:0] gapCnt;
  logic [AW-1:0] accCnt;
  logic          gapWrap;
  logic          stbQ;
  logic          pendQ;

  assign gapWrap = (gapCnt == GW'(PERIOD - 1));

  // Free-running interval counter; strobe registered on wrap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
      stbQ   <= 1'b0;
    end else begin
      stbQ   <= gapWrap;
      gapCnt <= gapWrap ? '0 : gapCnt + GW'(1);
    end
  end

  // Pending refresh: armed with the strobe, dropped when the sequence starts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (gapWrap) begin
      pendQ <= 1'b1;
    end else if (ctl.pendClear) begin
      pendQ <= 1'b0;
    end
  end

  // Access length counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accCnt <= '0;
    end else if (ctl.accStart) begin
      accCnt <= '0;
    end else if (ctl.accStep) begin
      accCnt <= accCnt + AW'(1);
    end
  end

  assign status.pending    = pendQ;
  assign status.accExpired = (accCnt == AW'(ACCESS_LIMIT - 1));
  assign refreshStb        = stbQ;

endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import dram_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accReq,
  input  logic       accDone,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output memState_e  state
);

  memState_e stQ;
  memState_e stD;

  always_comb begin
    stD = stQ;
    unique case (stQ)
      ST_IDLE: begin
        if (status.pending)  stD = ST_CBR_CAS;
        else if (accReq)     stD = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (accDone || status.accExpired) stD = ST_IDLE;
      end
      ST_CBR_CAS:    stD = ST_CBR_GAP;
      ST_CBR_GAP:    stD = ST_CBR_BOTH_A;
      ST_CBR_BOTH_A: stD = ST_CBR_BOTH_B;
      ST_CBR_BOTH_B: stD = ST_CBR_CLOSE;
      ST_CBR_CLOSE:  stD = ST_IDLE;
      default:       stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  always_comb begin
    ctl.accStart  = (stQ == ST_IDLE) && !status.pending && accReq;
    ctl.accStep   = (stQ == ST_ACCESS);
    ctl.pendClear = (stQ == ST_IDLE) && status.pending;
  end

  assign state = stQ;

endmodule

// File: rtl/refresh_pin_decode.sv
module refresh_pin_decode
  import dram_refresh_pkg::*;
(
  input  memState_e state,
  output pinSet_t   pins
);

  always_comb begin
    pins = '{rasN: 1'b1, casN: 1'b1, weN: 1'b1};
    unique case (state)
      ST_ACCESS:     pins.rasN = 1'b0;
      ST_CBR_CAS,
      ST_CBR_GAP:    pins.casN = 1'b0;
      ST_CBR_BOTH_A,
      ST_CBR_BOTH_B: begin
        pins.rasN = 1'b0;
        pins.casN = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL     = 24,
  parameter int ACCESS_LIMIT = 14
) (
  input  logic       clk,
  input  logic       reset_n,
  input  logic       accReq,
  input  logic       accDone,
  output logic       rasN,
  output logic       casN,
  output logic       weN,
  output logic       refreshStb,
  output logic [2:0] memState
);

  ctlStrobe_t ctl;
  dpStatus_t  status;
  memState_e  state;
  pinSet_t    pins;

  refresh_datapath #(
    .INTERVAL    (INTERVAL),
    .ACCESS_LIMIT(ACCESS_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (reset_n),
    .ctl       (ctl),
    .status    (status),
    .refreshStb(refreshStb)
  );

  refresh_control u_ctl (
    .clk    (clk),
    .rstN   (reset_n),
    .accReq (accReq),
    .accDone(accDone),
    .status (status),
    .ctl    (ctl),
    .state  (state)
  );

  refresh_pin_decode u_pins (
    .state(state),
    .pins (pins)
  );

  assign rasN     = pins.rasN;
  assign casN     = pins.casN;
  assign weN      = pins.weN;
  assign memState = state;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL     = 24,
  parameter int ACCESS_LIMIT = 14
) (
  input logic       clk,
  input logic       reset_n,
  input logic       accReq,
  input logic       accDone,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       refreshStb,
  input logic [2:0] memState
);

  localparam int PERIOD = INTERVAL + 1;
  localparam int GW     = $clog2(PERIOD + 2) + 1;
  localparam int AW     = $clog2(ACCESS_LIMIT + 2) + 1;

  logic [GW-1:0] sinceStb;
  logic [AW-1:0] outCnt;
  logic [AW-1:0] accRun;
  logic          trk;

  // Edges since reset release or the last strobe.
  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n)                   sinceStb <= '0;
    else if (refreshStb)            sinceStb <= GW'(1);
    else if (sinceStb <= GW'(PERIOD)) sinceStb <= sinceStb + GW'(1);
  end

  // Track a refresh from strobe to the start of its sequence.
  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      trk    <= 1'b0;
      outCnt <= '0;
    end else if (refreshStb) begin
      trk    <= 1'b1;
      outCnt <= (memState != ST_IDLE) ? AW'(1) : '0;
    end else begin
      if (memState == ST_CBR_CAS) trk <= 1'b0;
      if (trk && memState != ST_IDLE && memState != ST_CBR_CAS &&
          outCnt <= AW'(ACCESS_LIMIT))
        outCnt <= outCnt + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n)                     accRun <= '0;
    else if (memState == ST_ACCESS)   accRun <= (accRun <= AW'(ACCESS_LIMIT)) ? accRun + AW'(1) : accRun;
    else                              accRun <= '0;
  end

  // R1
  always_ff @(posedge clk) begin
    if (!reset_n) begin
      reset_quiet_chk: assert (rasN && casN && weN && !refreshStb && memState == ST_IDLE)
        else $error("reset state violated");
    end
  end

  // R2 R3 R10
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!reset_n)
    refreshStb == (sinceStb == GW'(PERIOD)));

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!reset_n)
    refreshStb |=> !refreshStb);

  // R4
  idle_pins_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_IDLE) |-> (rasN && casN && weN));

  // R5
  access_pins_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_ACCESS) |-> (!rasN && casN && weN));

  // R6
  access_cap_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_ACCESS) |-> (accRun < AW'(ACCESS_LIMIT)));

  // R7
  no_grant_chk: assert property (@(posedge clk) disable iff (!reset_n)
    ((refreshStb || trk) && memState == ST_IDLE && accReq) |=> (memState != ST_ACCESS));

  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (!reset_n)
    trk |-> (outCnt <= AW'(ACCESS_LIMIT)));

  // R8
  idle_to_cas_chk: assert property (@(posedge clk) disable iff (!reset_n)
    ((refreshStb || trk) && memState == ST_IDLE) |=> (memState == ST_CBR_CAS));

  // R9
  cas_first_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_CBR_CAS) |-> (rasN && !casN && weN));

  // R9
  cas_to_gap_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_CBR_CAS) |=> (memState == ST_CBR_GAP));

  // R9
  gap_to_both_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_CBR_GAP) |=> (memState == ST_CBR_BOTH_A && !rasN && !casN && weN));

  // R9
  both_twice_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_CBR_BOTH_A) |=> (memState == ST_CBR_BOTH_B && !rasN && !casN && weN));

  // R9
  close_high_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (memState == ST_CBR_BOTH_B) |=> (memState == ST_CBR_CLOSE && rasN && casN));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .INTERVAL    (INTERVAL),
  .ACCESS_LIMIT(ACCESS_LIMIT)
) u_chk (
  .clk       (clk),
  .reset_n   (reset_n),
  .accReq    (accReq),
  .accDone   (accDone),
  .rasN      (rasN),
  .casN      (casN),
  .weN       (weN),
  .refreshStb(refreshStb),
  .memState  (memState)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;

  localparam int CLK_PERIOD   = 10;
  localparam int INTERVAL     = 24;
  localparam int ACCESS_LIMIT = 14;
  localparam int PERIOD       = INTERVAL + 1;

  logic       clk = 1'b0;
  logic       reset_n = 1'b0;
  logic       accReq = 1'b0;
  logic       accDone = 1'b0;
  logic       rasN, casN, weN, refreshStb;
  logic [2:0] memState;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  dram_refresh_seq #(
    .INTERVAL    (INTERVAL),
    .ACCESS_LIMIT(ACCESS_LIMIT)
  ) u_dut (
    .clk(clk), .reset_n(reset_n), .accReq(accReq), .accDone(accDone),
    .rasN(rasN), .casN(casN), .weN(weN), .refreshStb(refreshStb), .memState(memState)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  int mCnt = 0, mState = 0, mAcc = 0;
  bit mStb = 0, mPend = 0;

  always @(negedge reset_n) begin
    mCnt = 0; mState = 0; mAcc = 0; mStb = 0; mPend = 0;
  end

  always @(posedge clk) begin
    if (reset_n) begin : mdl
      bit fire;
      int nState;
      fire   = (mCnt == PERIOD - 1);
      nState = mState;
      case (mState)
        0: if (mPend) nState = 2;
           else if (accReq) begin nState = 1; mAcc = 1; end
        1: if (accDone || mAcc == ACCESS_LIMIT) nState = 0;
           else mAcc++;
        6: nState = 0;
        default: nState = mState + 1;
      endcase
      if (fire) mPend = 1;
      else if (mState == 0 && mPend) mPend = 0;
      mCnt   = fire ? 0 : mCnt + 1;
      mStb   = fire;
      mState = nState;
    end
  end

  function automatic logic [2:0] expPins(input int s);
    case (s)
      1:       return 3'b011;
      2, 3:    return 3'b101;
      4, 5:    return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      string tag;
      tag = !reset_n ? "R1" : (mState == 0) ? "R4" : (mState == 1) ? "R5" : "R9";
      chk(tag, "pins", {29'd0, rasN, casN, weN}, {29'd0, expPins(mState)});
      chk(tag, "state", {29'd0, memState}, mState);
      chk("R3", "strobe", {31'd0, refreshStb}, {31'd0, mStb});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset condition
    chk("R1", "pins in reset", {29'd0, rasN, casN, weN}, 7);
    chk("R1", "state in reset", {29'd0, memState}, 0);
    chk("R1", "strobe in reset", {31'd0, refreshStb}, 0);

    reset_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!refreshStb && n < 100);
    chk("R2", "edges to first strobe", n, PERIOD);

    n = 0;
    do begin @(negedge clk); n++; end while (!refreshStb && n < 100);
    chk("R3", "strobe spacing", n, PERIOD);

    // R9 full sequence from an idle strobe
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9", "sequence state", {29'd0, memState}, (i == 5) ? 0 : i + 2);
    end

    // R5 open and close an access
    accReq = 1'b1;
    @(negedge clk);
    chk("R5", "access entered", {29'd0, memState}, 1);
    accReq = 1'b0;
    @(negedge clk);
    accDone = 1'b1;
    @(negedge clk);
    chk("R5", "access closed by done", {29'd0, memState}, 0);
    accDone = 1'b0;

    // R6 access cap with done held low
    accReq = 1'b1;
    n = 0;
    while (memState != 3'd1 && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (memState == 3'd1 && n < 100) begin n++; @(negedge clk); end
    chk("R6", "capped access length", n, ACCESS_LIMIT);

    // R7 R8 strobes landing inside back-to-back capped accesses
    for (int k = 0; k < 12; k++) begin
      n = 0;
      do @(negedge clk); while (!refreshStb);
      while (memState != 3'd0 && n < 100) begin n++; @(negedge clk); end
      chk("R8", "non-idle cycles after strobe within bound", n <= ACCESS_LIMIT, 1);
      @(negedge clk);
      chk("R7", "request held off, refresh starts", {29'd0, memState}, 2);
      repeat (k % 5) @(negedge clk);
    end
    accReq = 1'b0;

    // Randomised traffic, compared cycle by cycle against the model
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      accReq  = ($urandom_range(0, 3) != 0);
      accDone = ($urandom_range(0, 4) == 0);
    end
    accReq = 1'b0; accDone = 1'b0;

    // R10 abort in the middle of the double-low phase
    n = 0;
    while (memState != 3'd4 && n < 200) begin @(negedge clk); n++; end
    chk("R10", "reached double-low phase", {29'd0, memState}, 4);
    #(CLK_PERIOD/4);
    reset_n = 1'b0;
    #1;
    chk("R10", "pins restored on abort", {29'd0, rasN, casN, weN}, 7);
    chk("R10", "state restored on abort", {29'd0, memState}, 0);
    @(negedge clk);
    @(negedge clk);
    reset_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!refreshStb && n < 100);
    chk("R10", "strobe retimed from release", n, PERIOD);

    repeat (10) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule